// File: doc/BRIEF.md
# Multi-Mode Effective Address Sequencer

This unit turns a memory operand description into an address and fetches the operand. A request carries a 3-bit addressing-mode code, a base register value, an index register value, a 2-bit scale code and a signed 16-bit displacement. The unit forms the effective address with 32-bit modulo arithmetic. It then drives a read port with a fixed one-cycle latency and returns three results: the address it finally read, the word it loaded and, in the write-back mode, a new value for the base register.

Five modes are supported:
- Base plus displacement.
- Base plus index.
- Base plus a scaled index plus displacement.
- Base plus displacement with write-back of the sum to the base register.
- Memory-indirect, where the word at base plus displacement is itself the address of the operand.

The indirect mode takes two dependent reads. Every other mode takes one.

A request is a single-cycle `start` pulse with its operands. The unit accepts it only when no other request is in flight. Completion is a single-cycle `done` pulse. The results stay on their outputs from that cycle until the next request is accepted.

Top module: `ea_sequencer`

## Requirements
- R1: While `rstN` is low, `done`, `rdEn` and `baseWrEn` are low.
- R2: Mode code 0 reads at `baseVal` plus `disp` sign-extended to 32 bits, modulo 2^32. For example, 400 plus 100 reads location 500.
- R3: Mode code 1 reads at `baseVal + indexVal`. The displacement and scale are not used.
- R4: Mode code 2 reads at `baseVal + (indexVal << scaleSel) + sext(disp)`. Scale codes 0, 1, 2 and 3 multiply the index by 1, 2, 4 and 8.
- R5: Mode code 3 reads at `baseVal + sext(disp)`. In the `done` cycle it raises `baseWrEn` with `baseWrData` equal to that sum. No other mode ever raises `baseWrEn`.
- R6: Mode code 4 first reads at `baseVal + sext(disp)`. It then reads at the word returned by that first read. `effAddr` is that returned word, and `operand` is the data from the second read.
- R7: Mode codes 5, 6 and 7 behave exactly as mode code 0.
- R8: Each memory reference is one cycle of `rdEn`. `rdData` is taken in the cycle after `rdEn`. The first read is issued in the cycle after the clock edge that accepts `start`.
- R9: `done` is high for exactly one cycle. That cycle is 3 cycles after the accepting edge for single-reference modes and 5 cycles after it for mode code 4. `effAddr` and `operand` are valid during `done`.
- R10: `start` is ignored from the accepting edge through the `done` cycle. A request presented in that window has no effect on any later read, result or write-back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request strobe, sampled only when idle |
| mode | input | 3 | Addressing-mode code |
| baseVal | input | 32 | Base register value |
| indexVal | input | 32 | Index register value |
| scaleSel | input | 2 | Index scale code (shift amount) |
| disp | input | 16 | Signed displacement |
| rdEn | output | 1 | Memory read request |
| rdAddr | output | 32 | Memory read address |
| rdData | input | 32 | Memory read data, valid the cycle after `rdEn` |
| done | output | 1 | One-cycle completion pulse |
| effAddr | output | 32 | Address of the final operand read |
| operand | output | 32 | Loaded operand |
| baseWrEn | output | 1 | Base register write enable (write-back mode only) |
| baseWrData | output | 32 | New base register value |

## Verification
The hardest situation to reach is a new request arriving while an earlier one is still in flight, and in particular arriving in the `done` cycle itself. At that point the control is about to become idle, so a wrongly ordered state check would take the request one cycle early. To reach it, the stimulus holds `start` high with fresh, different operands over every cycle from the first read through the `done` cycle. This is done behind a single-reference request, a write-back request and an indirect request. The per-clock reference model then requires that no extra read, no extra completion and no change in any result follows. The indirect chain is exercised with a memory whose contents are a scrambling function of the address, so each pointer sends the second read somewhere distinct.

// File: rtl/ea_seq_pkg.sv
package ea_seq_pkg;

  typedef enum logic [2:0] {
    MODE_DISP     = 3'd0,
    MODE_INDEX    = 3'd1,
    MODE_SCALED   = 3'd2,
    MODE_UPDATE   = 3'd3,
    MODE_INDIRECT = 3'd4
  } modeT;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_READ1 = 3'd1,
    ST_RESP1 = 3'd2,
    ST_READ2 = 3'd3,
    ST_RESP2 = 3'd4,
    ST_DONE  = 3'd5
  } stateT;

  // strobes from control to datapath
  typedef struct packed {
    logic latchReq;    // register computed address
    logic issueRead;   // drive a read this cycle
    logic usePtr;      // read address comes from fetched pointer
    logic capData;     // capture read response
    logic capPtrAddr;  // record pointer as final address
    logic doneStb;     // completion pulse
    logic baseWr;      // base write-back pulse
  } ctrlT;

endpackage

// File: rtl/ea_addr_gen.sv
module ea_addr_gen #(
  parameter int ADDR_W  = 32,
  parameter int DISP_W  = 16,
  parameter int SCALE_W = 2
) (
  input  logic [2:0]         mode,
  input  logic [ADDR_W-1:0]  baseVal,
  input  logic [ADDR_W-1:0]  indexVal,
  input  logic [SCALE_W-1:0] scaleSel,
  input  logic [DISP_W-1:0]  disp,
  output logic [ADDR_W-1:0]  eaNext
);
  import ea_seq_pkg::*;

  localparam int NUM_SCALE = 1 << SCALE_W;
  localparam int EXT_W     = ADDR_W - DISP_W;

  logic [ADDR_W-1:0] dispExt;
  logic [ADDR_W-1:0] shiftOpt [NUM_SCALE];
  logic [ADDR_W-1:0] scaledIdx;

  assign dispExt = {{EXT_W{disp[DISP_W-1]}}, disp};

  // one shifted copy of the index per scale code
  for (genvar s = 0; s < NUM_SCALE; s++) begin : g_scale
    assign shiftOpt[s] = indexVal << s;
  end

  assign scaledIdx = shiftOpt[scaleSel];

  always_comb begin
    case (modeT'(mode))
      MODE_INDEX:  eaNext = baseVal + indexVal;
      MODE_SCALED: eaNext = baseVal + scaledIdx + dispExt;
      default:     eaNext = baseVal + dispExt;
    endcase
  end

endmodule

// File: rtl/ea_datapath.sv
module ea_datapath #(
  parameter int ADDR_W = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ea_seq_pkg::ctrlT     ctrl,
  input  logic [ADDR_W-1:0]    eaNext,
  input  logic [ADDR_W-1:0]    rdData,
  output logic [ADDR_W-1:0]    rdAddr,
  output logic [ADDR_W-1:0]    effAddr,
  output logic [ADDR_W-1:0]    operand,
  output logic [ADDR_W-1:0]    baseWrData
);

  logic [ADDR_W-1:0] eaReg;
  logic [ADDR_W-1:0] dataReg;
  logic [ADDR_W-1:0] finalReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      eaReg    <= '0;
      dataReg  <= '0;
      finalReg <= '0;
    end else begin
      if (ctrl.latchReq) begin
        eaReg    <= eaNext;
        finalReg <= eaNext;
      end
      if (ctrl.capPtrAddr) finalReg <= dataReg;
      if (ctrl.capData)    dataReg  <= rdData;
    end
  end

  assign rdAddr     = ctrl.usePtr ? dataReg : eaReg;
  assign effAddr    = finalReg;
  assign operand    = dataReg;
  assign baseWrData = eaReg;

endmodule

// File: rtl/ea_control.sv
module ea_control (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [2:0]       mode,
  output ea_seq_pkg::ctrlT ctrl
);
  import ea_seq_pkg::*;

  stateT stateQ, stateD;
  logic  indirectQ;
  logic  updateQ;
  logic  accept;

  assign accept = (stateQ == ST_IDLE) && start;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ    <= ST_IDLE;
      indirectQ <= 1'b0;
      updateQ   <= 1'b0;
    end else begin
      stateQ <= stateD;
      if (accept) begin
        indirectQ <= (mode == MODE_INDIRECT);
        updateQ   <= (mode == MODE_UPDATE);
      end
    end
  end

  always_comb begin
    stateD = stateQ;
    ctrl   = '0;
    case (stateQ)
      ST_IDLE: begin
        if (start) begin
          ctrl.latchReq = 1'b1;
          stateD        = ST_READ1;
        end
      end
      ST_READ1: begin
        ctrl.issueRead = 1'b1;
        stateD         = ST_RESP1;
      end
      ST_RESP1: begin
        ctrl.capData = 1'b1;
        stateD       = indirectQ ? ST_READ2 : ST_DONE;
      end
      ST_READ2: begin
        ctrl.issueRead  = 1'b1;
        ctrl.usePtr     = 1'b1;
        ctrl.capPtrAddr = 1'b1;
        stateD          = ST_RESP2;
      end
      ST_RESP2: begin
        ctrl.capData = 1'b1;
        stateD       = ST_DONE;
      end
      ST_DONE: begin
        ctrl.doneStb = 1'b1;
        ctrl.baseWr  = updateQ;
        stateD       = ST_IDLE;
      end
      default: stateD = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/ea_sequencer.sv
module ea_sequencer #(
  parameter int ADDR_W  = 32,
  parameter int DISP_W  = 16,
  parameter int SCALE_W = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic [2:0]         mode,
  input  logic [ADDR_W-1:0]  baseVal,
  input  logic [ADDR_W-1:0]  indexVal,
  input  logic [SCALE_W-1:0] scaleSel,
  input  logic [DISP_W-1:0]  disp,
  output logic               rdEn,
  output logic [ADDR_W-1:0]  rdAddr,
  input  logic [ADDR_W-1:0]  rdData,
  output logic               done,
  output logic [ADDR_W-1:0]  effAddr,
  output logic [ADDR_W-1:0]  operand,
  output logic               baseWrEn,
  output logic [ADDR_W-1:0]  baseWrData
);
  import ea_seq_pkg::*;

  ctrlT              ctrl;
  logic [ADDR_W-1:0] eaNext;

  ea_addr_gen #(
    .ADDR_W (ADDR_W),
    .DISP_W (DISP_W),
    .SCALE_W(SCALE_W)
  ) u_addrGen (
    .mode    (mode),
    .baseVal (baseVal),
    .indexVal(indexVal),
    .scaleSel(scaleSel),
    .disp    (disp),
    .eaNext  (eaNext)
  );

  ea_control u_control (
    .clk  (clk),
    .rstN (rstN),
    .start(start),
    .mode (mode),
    .ctrl (ctrl)
  );

  ea_datapath #(
    .ADDR_W(ADDR_W)
  ) u_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .ctrl      (ctrl),
    .eaNext    (eaNext),
    .rdData    (rdData),
    .rdAddr    (rdAddr),
    .effAddr   (effAddr),
    .operand   (operand),
    .baseWrData(baseWrData)
  );

  assign rdEn     = ctrl.issueRead;
  assign done     = ctrl.doneStb;
  assign baseWrEn = ctrl.baseWr;

endmodule

// File: rtl/ea_seq_checker.sv
module ea_seq_checker #(
  parameter int ADDR_W = 32,
  parameter int DISP_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic [2:0]        mode,
  input logic [ADDR_W-1:0] baseVal,
  input logic [DISP_W-1:0] disp,
  input logic              rdEn,
  input logic              done,
  input logic [ADDR_W-1:0] effAddr,
  input logic              baseWrEn,
  input logic [ADDR_W-1:0] baseWrData
);
  localparam int EXT_W = ADDR_W - DISP_W;

  logic              pending;
  logic [2:0]        modeL;
  logic [ADDR_W-1:0] baseL;
  logic [DISP_W-1:0] dispL;
  logic [1:0]        readsSeen;
  logic [ADDR_W-1:0] sumL;

  assign sumL = baseL + {{EXT_W{dispL[DISP_W-1]}}, dispL};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pending   <= 1'b0;
      modeL     <= '0;
      baseL     <= '0;
      dispL     <= '0;
      readsSeen <= '0;
    end else if (!pending) begin
      if (start) begin
        pending   <= 1'b1;
        modeL     <= mode;
        baseL     <= baseVal;
        dispL     <= disp;
        readsSeen <= '0;
      end
    end else begin
      if (done) pending <= 1'b0;
      if (rdEn) readsSeen <= readsSeen + 2'd1;
    end
  end

  AST_NO_IDLE_READ: assert property (@(posedge clk) disable iff (!rstN)
    rdEn |-> pending); // R8
  AST_READ_GAP: assert property (@(posedge clk) disable iff (!rstN)
    rdEn |=> !rdEn); // R8
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R9
  AST_DONE_OWNED: assert property (@(posedge clk) disable iff (!rstN)
    done |-> pending); // R10
  AST_READ_COUNT: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (readsSeen == ((modeL == 3'd4) ? 2'd2 : 2'd1))); // R6
  AST_WB_ONLY_UPDATE: assert property (@(posedge clk) disable iff (!rstN)
    baseWrEn |-> (done && modeL == 3'd3 && baseWrData == sumL)); // R5
  AST_WB_PRESENT: assert property (@(posedge clk) disable iff (!rstN)
    (done && modeL == 3'd3) |-> baseWrEn); // R5
  AST_DISP_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    (done && modeL == 3'd0) |-> (effAddr == sumL)); // R2

endmodule

bind ea_sequencer ea_seq_checker #(
  .ADDR_W(ADDR_W),
  .DISP_W(DISP_W)
) u_eaSeqChecker (
  .clk       (clk),
  .rstN      (rstN),
  .start     (start),
  .mode      (mode),
  .baseVal   (baseVal),
  .disp      (disp),
  .rdEn      (rdEn),
  .done      (done),
  .effAddr   (effAddr),
  .baseWrEn  (baseWrEn),
  .baseWrData(baseWrData)
);

// File: tb/test_ea_sequencer.sv
module test_ea_sequencer;

  logic        clk = 1'b0;
  logic        rstN;
  logic        start;
  logic [2:0]  mode;
  logic [31:0] baseVal;
  logic [31:0] indexVal;
  logic [1:0]  scaleSel;
  logic [15:0] disp;
  logic        rdEn;
  logic [31:0] rdAddr;
  logic [31:0] rdData;
  logic        done;
  logic [31:0] effAddr;
  logic [31:0] operand;
  logic        baseWrEn;
  logic [31:0] baseWrData;

  always #5 clk = ~clk;

  ea_sequencer i_ea_sequencer (
    .clk(clk), .rstN(rstN), .start(start), .mode(mode),
    .baseVal(baseVal), .indexVal(indexVal), .scaleSel(scaleSel), .disp(disp),
    .rdEn(rdEn), .rdAddr(rdAddr), .rdData(rdData), .done(done),
    .effAddr(effAddr), .operand(operand), .baseWrEn(baseWrEn), .baseWrData(baseWrData)
  );

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  function automatic logic [31:0] memFn(input logic [31:0] a);
    return (a ^ 32'h3C5A_96E1) * 32'd40503 + 32'h0000_1F2B;
  endfunction

  // memory with one cycle of read latency
  always @(posedge clk) rdData <= rdEn ? memFn(rdAddr) : 32'h0;

  function automatic logic [31:0] calcEa(input logic [2:0] m, input logic [31:0] b,
                                         input logic [31:0] x, input logic [1:0] s,
                                         input logic [15:0] d);
    logic [31:0] dx;
    dx = {{16{d[15]}}, d};
    if (m == 3'd1)      return b + x;
    else if (m == 3'd2) return b + x * (32'd1 << s) + dx;
    else                return b + dx;
  endfunction

  function automatic string tagFor(input logic [2:0] m);
    case (m)
      3'd0: return "R2";
      3'd1: return "R3";
      3'd2: return "R4";
      3'd3: return "R5";
      3'd4: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // behavioural reference model
  int          cyc = 0;
  bit          mBusy = 0;
  int          mAcc = 0;
  bit          mInd = 0;
  bit          mUpd = 0;
  logic [31:0] mEa, mPtr, mFinal, mOp;
  string       mTag = "R2";
  bit          overlapFlag = 0;

  always @(posedge clk) begin
    if (!rstN) mBusy = 0;
    else if (mBusy) begin
      if (cyc == mAcc + (mInd ? 5 : 3)) mBusy = 0;
    end else if (start) begin
      mBusy  = 1;
      mAcc   = cyc;
      mInd   = (mode == 3'd4);
      mUpd   = (mode == 3'd3);
      mEa    = calcEa(mode, baseVal, indexVal, scaleSel, disp);
      mPtr   = memFn(mEa);
      mFinal = mInd ? mPtr : mEa;
      mOp    = memFn(mFinal);
      mTag   = overlapFlag ? "R10" : tagFor(mode);
    end
    cyc++;
  end

  always @(negedge clk) begin
    bit eDone;
    bit eRd;
    if (!rstN) begin
      chk(done == 1'b0, "R1", "done in reset", {31'b0, done}, 32'h0);
      chk(rdEn == 1'b0, "R1", "rdEn in reset", {31'b0, rdEn}, 32'h0);
      chk(baseWrEn == 1'b0, "R1", "baseWrEn in reset", {31'b0, baseWrEn}, 32'h0);
    end else begin
      eDone = mBusy && (cyc == mAcc + (mInd ? 5 : 3));
      eRd   = mBusy && ((cyc == mAcc + 1) || (mInd && cyc == mAcc + 3));
      chk(done == eDone, "R9", "done timing", {31'b0, done}, {31'b0, eDone});
      chk(rdEn == eRd, "R8", "rdEn timing", {31'b0, rdEn}, {31'b0, eRd});
      chk(baseWrEn == (eDone && mUpd), "R5", "baseWrEn", {31'b0, baseWrEn},
          {31'b0, eDone && mUpd});
      if (eRd)
        chk(rdAddr == ((cyc == mAcc + 1) ? mEa : mPtr), mTag, "rdAddr", rdAddr,
            (cyc == mAcc + 1) ? mEa : mPtr);
      if (eDone) begin
        chk(effAddr == mFinal, mTag, "effAddr", effAddr, mFinal);
        chk(operand == mOp, mTag, "operand", operand, mOp);
        if (mUpd) chk(baseWrData == mEa, mTag, "baseWrData", baseWrData, mEa);
      end
    end
  end

  task automatic setIn(input logic [2:0] m, input logic [31:0] b, input logic [31:0] x,
                       input logic [1:0] s, input logic [15:0] d);
    mode = m; baseVal = b; indexVal = x; scaleSel = s; disp = d;
  endtask

  task automatic req(input logic [2:0] m, input logic [31:0] b, input logic [31:0] x,
                     input logic [1:0] s, input logic [15:0] d);
    @(negedge clk);
    setIn(m, b, x, s, d);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (mBusy) @(negedge clk);
  endtask

  // R10: start held high with other operands through the whole request
  task automatic reqOverlap(input logic [2:0] m, input logic [31:0] b, input logic [15:0] d);
    @(negedge clk);
    setIn(m, b, 32'h0000_0040, 2'd1, d);
    start = 1'b1;
    overlapFlag = 1;
    @(negedge clk);
    overlapFlag = 0;
    while (mBusy) begin
      setIn(3'(cyc % 5), b ^ 32'h0F0F_0000, 32'(cyc), 2'(cyc), 16'(cyc * 7));
      @(negedge clk);
    end
    start = 1'b0;
    while (mBusy) @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0;
    start = 1'b0;
    setIn(3'd0, 32'h0, 32'h0, 2'd0, 16'h0);
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    // R2: displacement, positive, negative, wrap-around
    req(3'd0, 32'd400, 32'h0, 2'd0, 16'd100);
    req(3'd0, 32'h0000_1000, 32'hFFFF_FFFF, 2'd3, 16'hFFF0);
    req(3'd0, 32'hFFFF_FFF0, 32'h0, 2'd0, 16'h0020);
    // R3: index, displacement and scale unused
    req(3'd1, 32'h0000_2000, 32'h0000_0124, 2'd3, 16'h7FFF);
    req(3'd1, 32'hFFFF_FF00, 32'h0000_0200, 2'd2, 16'h8000);
    // R4: all scale codes
    for (int s = 0; s < 4; s++)
      req(3'd2, 32'h0001_0000, 32'h0000_0013, 2'(s), 16'hFFFC);
    // R5: write-back mode
    req(3'd3, 32'h0000_8000, 32'h0, 2'd0, 16'd24);
    req(3'd3, 32'h0000_0010, 32'h5, 2'd1, 16'hFFE0);
    // R6: indirect
    req(3'd4, 32'h0000_4000, 32'h0, 2'd0, 16'd8);
    req(3'd4, 32'h1234_5678, 32'h9, 2'd2, 16'hFF00);
    // R7: reserved codes act as displacement
    req(3'd5, 32'h0000_0300, 32'h77, 2'd1, 16'd12);
    req(3'd6, 32'h0000_0300, 32'h77, 2'd2, 16'hFFFE);
    req(3'd7, 32'hAAAA_0000, 32'h77, 2'd3, 16'h0100);
    // R10: overlapping start requests
    reqOverlap(3'd0, 32'h0000_5000, 16'd4);
    reqOverlap(3'd3, 32'h0000_6000, 16'hFFF8);
    reqOverlap(3'd4, 32'h0000_7000, 16'd16);
    repeat (3) @(negedge clk);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule